// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break and Idle Preamble

This block serialises words onto a single line in the usual asynchronous frame: a low start bit, the data bits least significant first, and a high stop bit. It holds one word in a buffer and one character in a shift register. Software writes a word with a one-cycle strobe. The buffer hands the word to the shift register at a bit-time boundary, so a steady writer gets frames back to back with no gap. A one-cycle tick from an external rate divider sets the bit time. The block does not divide the clock and does not generate parity.

The block can also send two special characters. A break is a run of zeros with no start or stop bit. Its length can be raised to the 13 bit times that LIN masters need. Breaks repeat while the break request is held. When the request is released, the break in progress completes and is followed by a mark of at least one bit time, so that the next start bit can be recognised. An idle preamble is a character of all ones. It is queued whenever the transmit enable is seen low, and it is sent first once the enable returns. Clearing and then setting the enable therefore separates two messages with a synchronising gap.

Dropping the enable never cuts a character short. The character in the shift register completes, and the line then rests high. Software that must not lose its last frame waits for the buffer-empty flag before it clears the enable, or waits for the transmit-complete flag.

Top module: `utx_core`

## Requirements
- R1: The txd line is 1 whenever no character is shifting. This includes the time while the transmitter is disabled, even if the buffer holds a word.
- R2: With mode_9bit=0 a data frame is 10 bit times: a 0, then wr_data[7:0] least significant bit first, then a 1. wr_data[8] is ignored in this mode. If the buffer holds a word when a frame ends, the next frame starts on the very next bit time.
- R3: buf_empty falls in the cycle after a wr_valid strobe. It rises on the bit_tick at which the buffered word enters the shift register, which is the tick that drives the start bit.
- R4: With mode_9bit=1 a data frame is 11 bit times: a 0, then wr_data[8:0] least significant bit first, then a 1.
- R5: A break is all zeros with no start or stop bit. It lasts 10 bit times with (mode_9bit, break13)=(0,0), 11 with (1,0), 13 with (0,1) and 14 with (1,1). A pending break is sent before a buffered word.
- R6: While send_break stays high, break characters follow one another with no high bit between them.
- R7: After send_break is released, the break in progress completes. Then exactly one bit time of 1 is driven, and a buffered word may start on the following bit time.
- R8: If tx_enable falls while a character is shifting, that character completes unchanged. Nothing new starts until tx_enable is high again.
- R9: Once tx_enable has been seen low, the first bit_tick with tx_enable high starts an idle preamble of all ones. It lasts 10 bit times (11 with mode_9bit=1) and is sent whether or not a word is waiting. A waiting word stays buffered until the preamble ends. After reset a preamble is also pending.
- R10: tx_done is 1 exactly when the buffer is empty and no data, break, mark or preamble character is shifting.
- R11: txd changes only on the clock edge at which bit_tick is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse marking each bit-time boundary |
| tx_enable | input | 1 | Transmitter enable; a low level queues a preamble |
| send_break | input | 1 | Request for break characters, held for as long as breaks are wanted |
| mode_9bit | input | 1 | 0: eight data bits; 1: nine data bits |
| break13 | input | 1 | Lengthens a break by three bit times |
| wr_valid | input | 1 | Write strobe for the buffer |
| wr_data | input | 9 | Word to send; bit 8 is used only in nine-bit mode |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Buffer can accept a word |
| tx_done | output | 1 | Buffer empty and nothing shifting |

## Verification
The bench aims at the seams between characters. A back-to-back data pair would show a spurious high bit if the buffer were consulted one tick late. A released break would either drop its trailing mark or start the next frame inside it. A held break would let a high bit slip in between repeats. The bench also drops the enable in the middle of a frame: a design that honoured the enable at once would truncate the frame, and one that forgot to queue a preamble would start the buffered word at once on re-enable. A preamble sent with nothing buffered checks that transmit-complete stays low through an all-ones character, which a line-level check alone cannot see. The four break lengths and the ignored ninth bit in eight-bit mode catch counters that are off by one or a data mux that ignores the mode.

// File: rtl/utx_pkg.sv
package utx_pkg;

   // Kind of character currently held by the shift engine
   typedef enum logic [2:0] {
      CH_NONE     = 3'd0,
      CH_DATA     = 3'd1,
      CH_BREAK    = 3'd2,
      CH_MARK     = 3'd3,
      CH_PREAMBLE = 3'd4
   } char_kind_t;

endpackage

// File: rtl/utx_holdbuf.sv
module utx_holdbuf #(
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] word
);

   if (DATA_W < 2) begin : g_bad_width
      $error("utx_holdbuf: DATA_W must be at least 2");
   end

   // A write in the same cycle as a take refills the slot; a write while
   // full replaces the stored word.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full <= 1'b0;
         word <= '0;
      end else begin
         if (wr_valid) begin
            word <= wr_data;
         end
         full <= wr_valid | (full & ~take);
      end
   end

endmodule

// File: rtl/utx_charsel.sv
module utx_charsel
   import utx_pkg::*;
#(
   parameter int DATA_W    = 9,
   parameter int BRK_EXTRA = 3,
   parameter int MARK_W    = 1,
   parameter int SR_W      = DATA_W + 2 + BRK_EXTRA,
   parameter int CNT_W     = $clog2(SR_W + 1)
) (
   input  logic              tx_enable,
   input  logic              send_break,
   input  logic              mode_9bit,
   input  logic              break13,
   input  logic              buf_full,
   input  logic [DATA_W-1:0] buf_word,
   input  logic              pre_pend,
   input  char_kind_t        cur_kind,
   output char_kind_t        nxt_kind,
   output logic [SR_W-1:0]   nxt_pat,
   output logic [CNT_W-1:0]  nxt_len
);

   localparam int LEN_SHORT = DATA_W + 1;
   localparam int LEN_LONG  = DATA_W + 2;

   if (SR_W < LEN_LONG + BRK_EXTRA) begin : g_bad_sr
      $error("utx_charsel: shift register too short for longest break");
   end
   if (MARK_W < 1 || MARK_W > SR_W) begin : g_bad_mark
      $error("utx_charsel: MARK_W out of range");
   end
   if ((1 << CNT_W) <= SR_W) begin : g_bad_cnt
      $error("utx_charsel: CNT_W cannot hold the longest character");
   end

   // Data frame image, bit 0 first on the line
   logic [SR_W-1:0] frame_pat;

   for (genvar gi = 0; gi < SR_W; gi++) begin : g_pat
      if (gi == 0) begin : g_start
         assign frame_pat[gi] = 1'b0;
      end else if (gi < DATA_W) begin : g_data
         assign frame_pat[gi] = buf_word[gi-1];
      end else if (gi == DATA_W) begin : g_top
         assign frame_pat[gi] = mode_9bit ? buf_word[DATA_W-1] : 1'b1;
      end else begin : g_stop
         assign frame_pat[gi] = 1'b1;
      end
   end

   logic [CNT_W-1:0] frame_len;
   logic [CNT_W-1:0] brk_len;
   logic             brk_ending;

   assign frame_len  = mode_9bit ? CNT_W'(LEN_LONG) : CNT_W'(LEN_SHORT);
   assign brk_len    = frame_len + (break13 ? CNT_W'(BRK_EXTRA) : CNT_W'(0));
   assign brk_ending = (cur_kind == CH_BREAK);

   // Priority at a character boundary: enable, trailing mark, preamble,
   // break, buffered word.
   always_comb begin
      nxt_kind = CH_NONE;
      nxt_pat  = '1;
      nxt_len  = CNT_W'(1);
      if (!tx_enable) begin
         nxt_kind = CH_NONE;
      end else if (brk_ending && !send_break) begin
         nxt_kind = CH_MARK;
         nxt_len  = CNT_W'(MARK_W);
      end else if (pre_pend) begin
         nxt_kind = CH_PREAMBLE;
         nxt_len  = frame_len;
      end else if (send_break) begin
         nxt_kind = CH_BREAK;
         nxt_pat  = '0;
         nxt_len  = brk_len;
      end else if (buf_full) begin
         nxt_kind = CH_DATA;
         nxt_pat  = frame_pat;
         nxt_len  = frame_len;
      end
   end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
   import utx_pkg::*;
#(
   parameter int SR_W  = 14,
   parameter int CNT_W = $clog2(SR_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  char_kind_t       nxt_kind,
   input  logic [SR_W-1:0]  nxt_pat,
   input  logic [CNT_W-1:0] nxt_len,
   output logic             txd,
   output char_kind_t       cur_kind,
   output logic             busy,
   output logic             boundary
);

   if (SR_W < 2) begin : g_bad_sr
      $error("utx_shifter: SR_W must be at least 2");
   end

   logic [SR_W-2:0]  sr;
   logic [CNT_W-1:0] left;

   assign busy     = (cur_kind != CH_NONE);
   assign boundary = bit_tick && (!busy || left == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         txd      <= 1'b1;
         sr       <= '1;
         left     <= '0;
         cur_kind <= CH_NONE;
      end else if (bit_tick) begin
         if (!boundary) begin
            txd  <= sr[0];
            sr   <= {1'b1, sr[SR_W-2:1]};
            left <= left - CNT_W'(1);
         end else if (nxt_kind != CH_NONE) begin
            txd      <= nxt_pat[0];
            sr       <= nxt_pat[SR_W-1:1];
            left     <= nxt_len - CNT_W'(1);
            cur_kind <= nxt_kind;
         end else begin
            txd      <= 1'b1;
            sr       <= '1;
            left     <= '0;
            cur_kind <= CH_NONE;
         end
      end
   end

endmodule

// File: rtl/utx_core.sv
module utx_core
   import utx_pkg::*;
#(
   parameter int DATA_W    = 9,
   parameter int BRK_EXTRA = 3,
   parameter int MARK_W    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              tx_enable,
   input  logic              send_break,
   input  logic              mode_9bit,
   input  logic              break13,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              txd,
   output logic              buf_empty,
   output logic              tx_done
);

   localparam int SR_W  = DATA_W + 2 + BRK_EXTRA;
   localparam int CNT_W = $clog2(SR_W + 1);

   if (DATA_W < 2) begin : g_bad_width
      $error("utx_core: DATA_W must be at least 2");
   end
   if (BRK_EXTRA < 0) begin : g_bad_extra
      $error("utx_core: BRK_EXTRA must not be negative");
   end

   logic              buf_full;
   logic [DATA_W-1:0] buf_word;
   logic              take;
   logic              pre_pend;
   logic              sh_busy;
   logic              boundary;
   char_kind_t        cur_kind;
   char_kind_t        nxt_kind;
   logic [SR_W-1:0]   nxt_pat;
   logic [CNT_W-1:0]  nxt_len;

   assign take = boundary && (nxt_kind == CH_DATA);

   utx_holdbuf #(
      .DATA_W (DATA_W)
   ) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .wr_data  (wr_data),
      .take     (take),
      .full     (buf_full),
      .word     (buf_word)
   );

   utx_charsel #(
      .DATA_W    (DATA_W),
      .BRK_EXTRA (BRK_EXTRA),
      .MARK_W    (MARK_W),
      .SR_W      (SR_W),
      .CNT_W     (CNT_W)
   ) u_sel (
      .tx_enable  (tx_enable),
      .send_break (send_break),
      .mode_9bit  (mode_9bit),
      .break13    (break13),
      .buf_full   (buf_full),
      .buf_word   (buf_word),
      .pre_pend   (pre_pend),
      .cur_kind   (cur_kind),
      .nxt_kind   (nxt_kind),
      .nxt_pat    (nxt_pat),
      .nxt_len    (nxt_len)
   );

   utx_shifter #(
      .SR_W  (SR_W),
      .CNT_W (CNT_W)
   ) u_sh (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick),
      .nxt_kind (nxt_kind),
      .nxt_pat  (nxt_pat),
      .nxt_len  (nxt_len),
      .txd      (txd),
      .cur_kind (cur_kind),
      .busy     (sh_busy),
      .boundary (boundary)
   );

   // Preamble request: armed by any cycle with the enable low, retired when
   // the preamble character is loaded.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_pend <= 1'b1;
      end else if (!tx_enable) begin
         pre_pend <= 1'b1;
      end else if (boundary && nxt_kind == CH_PREAMBLE) begin
         pre_pend <= 1'b0;
      end
   end

   assign buf_empty = ~buf_full;
   assign tx_done   = ~buf_full & ~sh_busy;

endmodule

// File: rtl/utx_checker.sv
module utx_checker (
   input logic clk,
   input logic rst_n,
   input logic bit_tick,
   input logic tx_enable,
   input logic wr_valid,
   input logic txd,
   input logic buf_empty,
   input logic tx_done,
   input logic sh_busy
);

   // R1: nothing buffered and nothing shifting means a high line
   a_r1_done_line_high: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> txd);

   // R11: line moves only on a bit boundary
   a_r11_txd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(txd) |-> $past(bit_tick));

   // R3: a write fills the buffer
   a_r3_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !buf_empty);

   // R3: the buffer drains only at a bit boundary
   a_r3_empty_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_empty) |-> $past(bit_tick));

   // R10: a shifting character holds tx_done low
   a_r10_busy_not_done: assert property (@(posedge clk) disable iff (!rst_n)
      sh_busy |-> !tx_done);

   // R8: a character ends only at a bit boundary, never on enable loss
   a_r8_busy_ends_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sh_busy) && !$past(bit_tick)) |-> sh_busy);

   // R8: a low edge out of idle needs the enable at that boundary
   a_r8_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(txd) && !$past(sh_busy)) |-> $past(tx_enable));

endmodule

bind utx_core utx_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_tick  (bit_tick),
   .tx_enable (tx_enable),
   .wr_valid  (wr_valid),
   .txd       (txd),
   .buf_empty (buf_empty),
   .tx_done   (tx_done),
   .sh_busy   (sh_busy)
);

// File: tb/test_utx_core.sv
module test_utx_core;

   localparam int TICK_DIV = 8;
   localparam int WD_LIMIT = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       tx_enable = 1'b0;
   logic       send_break = 1'b0;
   logic       mode_9bit = 1'b0;
   logic       break13 = 1'b0;
   logic       wr_valid = 1'b0;
   logic [8:0] wr_data = '0;
   logic       txd;
   logic       buf_empty;
   logic       tx_done;

   int n_chk  = 0;
   int n_fail = 0;
   int tick_no = 0;
   logic tick_d = 1'b0;
   int div = 0;

   typedef struct {
      logic  v;
      string tag;
   } exp_t;
   exp_t exp_q[$];

   utx_core i_utx_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_tick   (bit_tick),
      .tx_enable  (tx_enable),
      .send_break (send_break),
      .mode_9bit  (mode_9bit),
      .break13    (break13),
      .wr_valid   (wr_valid),
      .wr_data    (wr_data),
      .txd        (txd),
      .buf_empty  (buf_empty),
      .tx_done    (tx_done)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      div      <= (div == TICK_DIV - 1) ? 0 : div + 1;
      bit_tick <= (div == TICK_DIV - 1);
      tick_d   <= bit_tick;
      if (bit_tick) tick_no <= tick_no + 1;
   end

   task automatic chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Scoreboard monitor: one expected line bit per bit time
   always @(negedge clk) begin
      if (rst_n && tick_d && exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         chk(e.tag, int'(txd), int'(e.v));
      end
   end

   task automatic push_bits(logic v, int n, string tag);
      for (int i = 0; i < n; i++) exp_q.push_back('{v, tag});
   endtask

   task automatic push_frame(logic [8:0] d, logic nine, string tag);
      push_bits(1'b0, 1, tag);
      for (int i = 0; i < (nine ? 9 : 8); i++) push_bits(d[i], 1, tag);
      push_bits(1'b1, 1, tag);
   endtask

   task automatic goto_pre();
      do @(negedge clk); while (!bit_tick);
   endtask

   task automatic goto_after(int target);
      while (tick_no < target) @(negedge clk);
   endtask

   task automatic sync_after();
      goto_after(tick_no + 1);
   endtask

   task automatic write_word(logic [8:0] d);
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      int b;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 R3 R10: reset state
      chk("R1 reset line", int'(txd), 1);
      chk("R3 reset buffer empty", int'(buf_empty), 1);
      chk("R10 reset done", int'(tx_done), 1);

      // S2: word buffered while disabled, then enable -> preamble, frame
      sync_after();
      write_word(9'h1A5);
      chk("R3 write fills buffer", int'(buf_empty), 0);
      chk("R10 done low with word", int'(tx_done), 0);
      goto_after(tick_no + 2);
      chk("R1 disabled line stays high", int'(txd), 1);
      goto_pre();
      b = tick_no;
      tx_enable = 1'b1;
      push_bits(1'b1, 10, "R9 preamble ones");
      push_frame(9'h0A5, 1'b0, "R2 eight-bit frame, bit 8 ignored");
      push_bits(1'b1, 2, "R1 idle after frame");
      goto_after(b + 1);
      chk("R10 done low in preamble", int'(tx_done), 0);
      goto_after(b + 10);
      chk("R9 word held through preamble", int'(buf_empty), 0);
      goto_after(b + 11);
      chk("R3 empty at start-bit tick", int'(buf_empty), 1);
      goto_after(b + 20);
      chk("R10 done low on stop bit", int'(tx_done), 0);
      goto_after(b + 21);
      chk("R10 done after last bit", int'(tx_done), 1);
      drain();

      // S3: back-to-back frames
      sync_after();
      write_word(9'h03C);
      goto_pre();
      b = tick_no;
      push_frame(9'h03C, 1'b0, "R2 first frame");
      push_frame(9'h0C3, 1'b0, "R2 second frame with no gap");
      push_bits(1'b1, 2, "R1 idle");
      goto_after(b + 1);
      chk("R3 empty after load", int'(buf_empty), 1);
      write_word(9'h0C3);
      chk("R3 refilled", int'(buf_empty), 0);
      goto_after(b + 10);
      chk("R3 held until boundary", int'(buf_empty), 0);
      goto_after(b + 11);
      chk("R3 empty at second start", int'(buf_empty), 1);
      drain();

      // S4: nine-bit frame
      sync_after();
      mode_9bit = 1'b1;
      write_word(9'h13C);
      goto_pre();
      b = tick_no;
      push_frame(9'h13C, 1'b1, "R4 nine-bit frame");
      push_bits(1'b1, 2, "R1 idle");
      goto_after(b + 11);
      chk("R10 done low on nine-bit stop", int'(tx_done), 0);
      goto_after(b + 12);
      chk("R10 done after nine-bit frame", int'(tx_done), 1);
      drain();
      mode_9bit = 1'b0;

      // S5: short break beats waiting word, then mark, then frame
      sync_after();
      write_word(9'h00F);
      goto_pre();
      b = tick_no;
      send_break = 1'b1;
      push_bits(1'b0, 10, "R5 break 10");
      push_bits(1'b1, 1, "R7 mark after break");
      push_frame(9'h00F, 1'b0, "R7 frame after mark");
      push_bits(1'b1, 2, "R1 idle");
      goto_after(b + 3);
      send_break = 1'b0;
      chk("R5 word waits behind break", int'(buf_empty), 0);
      chk("R10 done low in break", int'(tx_done), 0);
      drain();

      // S6: held 13-bit break repeats
      sync_after();
      break13 = 1'b1;
      goto_pre();
      b = tick_no;
      send_break = 1'b1;
      push_bits(1'b0, 26, "R6 two breaks of 13 back to back");
      push_bits(1'b1, 4, "R7 mark then idle");
      goto_after(b + 15);
      send_break = 1'b0;
      drain();

      // S7: nine-bit breaks, long and short
      sync_after();
      mode_9bit = 1'b1;
      goto_pre();
      b = tick_no;
      send_break = 1'b1;
      push_bits(1'b0, 14, "R5 break 14");
      push_bits(1'b1, 3, "R7 mark then idle");
      goto_after(b + 2);
      send_break = 1'b0;
      drain();
      sync_after();
      break13 = 1'b0;
      goto_pre();
      b = tick_no;
      send_break = 1'b1;
      push_bits(1'b0, 11, "R5 break 11");
      push_bits(1'b1, 3, "R7 mark then idle");
      goto_after(b + 2);
      send_break = 1'b0;
      drain();
      mode_9bit = 1'b0;

      // S8: enable dropped mid-frame, word held, preamble on return
      sync_after();
      write_word(9'h081);
      goto_pre();
      b = tick_no;
      push_frame(9'h081, 1'b0, "R8 frame completes after enable drop");
      push_bits(1'b1, 15, "R8 line high while disabled, R9 preamble");
      push_frame(9'h055, 1'b0, "R9 frame after preamble");
      push_bits(1'b1, 2, "R1 idle");
      goto_after(b + 3);
      tx_enable = 1'b0;
      goto_after(b + 12);
      write_word(9'h055);
      goto_after(b + 14);
      chk("R8 word not sent while disabled", int'(buf_empty), 0);
      chk("R1 disabled line high", int'(txd), 1);
      goto_after(b + 15);
      tx_enable = 1'b1;
      goto_after(b + 20);
      chk("R10 done low in preamble", int'(tx_done), 0);
      goto_after(b + 25);
      chk("R9 word held to preamble end", int'(buf_empty), 0);
      goto_after(b + 26);
      chk("R3 empty at start after preamble", int'(buf_empty), 1);
      drain();

      // S9: preamble with nothing buffered
      goto_pre();
      b = tick_no;
      tx_enable = 1'b0;
      push_bits(1'b1, 15, "R9 preamble alone keeps line high");
      goto_after(b + 2);
      tx_enable = 1'b1;
      goto_after(b + 3);
      chk("R10 done low in bare preamble", int'(tx_done), 0);
      goto_after(b + 12);
      chk("R9 bare preamble lasts 10", int'(tx_done), 0);
      goto_after(b + 13);
      chk("R10 done after bare preamble", int'(tx_done), 1);
      drain();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", tick_no, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule